// File: doc/BRIEF.md
# GPIO Line Interrupt Controller

This block watches eight general-purpose input pins and turns their activity into interrupt requests. Each pin is first brought into the clock domain by a two-stage synchronizer. A per-line debounce filter can optionally be placed before detection. Each line is then sensed either by level or by edge, and the active polarity is programmable. Level-sensed lines report their condition continuously. Edge-sensed lines hold a sticky pending bit until software retires it by writing a one to the matching bit of the end-of-interrupt register.

Software reaches the block over a simple byte-wide register bus. A write takes effect on the clock edge where select and write are both high. Reads are combinational from the address. Software sees two status views: the raw pending condition, and the same condition gated by the per-line enable. A build parameter selects the output variant. One variant gives a single interrupt output that is the OR of the gated status. The other gives eight outputs, one per line. When software needs both edges, it flips a line's polarity after each event. The block guarantees that such reconfiguration never manufactures an event of its own.

Top module: `gpio_irq_unit`

## Requirements
- R1: After synchronous reset, the mode, polarity, enable and debounce registers read 0 and the interrupt output is low. Raw status reads 0xFF while all pins are low, because every line is then level-low sensed.
- R2: The registers decode at these byte addresses: mode at 0x00, polarity at 0x04, end-of-interrupt at 0x08, enable at 0x0C, gated status at 0x10, raw status at 0x14 and debounce at 0x18. The writable registers (mode, polarity, enable, debounce) read back what was written. The end-of-interrupt address reads 0, and any other address reads 0.
- R3: A mode bit of 0 selects level sensing for that line. Raw status is then 1 exactly when the sensed pin equals the polarity bit, and writes to end-of-interrupt do not change it.
- R4: A mode bit of 1 selects edge sensing. A polarity bit of 1 means a rising transition sets the line's raw bit, and 0 means a falling transition sets it. The opposite transition is ignored, and the bit stays set after the pin returns.
- R5: Writing 1 to end-of-interrupt bit n clears the pending edge of line n. Bits written as 0 leave their lines untouched. If a new qualifying edge arrives in the same cycle as the clear, the bit stays set.
- R6: Gated status bit n equals raw status bit n ANDed with enable bit n.
- R7: Writing mode or polarity never sets a raw bit in edge mode. A line placed in level mode discards its pending edge.
- R8: When a line's debounce bit is set, a pin change reaches detection only after it has held for DB_TICKS consecutive sample ticks (one tick every TICK_DIV clocks). A shorter glitch is rejected.
- R9: With PER_LINE=0, the single output is high exactly when any gated status bit is set. With PER_LINE=1, output n equals gated status bit n.
- R10: Writes to the gated status and raw status addresses change no register.
- R11: Without debounce, a pin change becomes visible in raw status after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | LINES | Asynchronous pin inputs |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data |
| irq_o | output | IRQ_W | Shared interrupt (width 1) or one output per line |

## Verification
The assertions watch properties that must hold on every clock. A pending edge may only rise when the sensed pin actually moved. A pending edge is sticky until cleared and is cleared when the clear arrives without a new event. A level-mode line holds no pending edge. The debounce output moves only on a tick, after a full run of differing samples. Writes to status addresses leave the configuration untouched. Only the bench's scenarios can show that polarity picks the right transition, that glitches shorter than the filter window are rejected, and that the pin-to-status latency is exactly two edges. The bench's behavioural model, compared on every cycle against both output variants, also covers the order of events when a clear and a new edge coincide.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADDR_MODE  = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_POL   = 5'h04;
    localparam logic [ADDR_W-1:0] ADDR_EOI   = 5'h08;
    localparam logic [ADDR_W-1:0] ADDR_EN    = 5'h0C;
    localparam logic [ADDR_W-1:0] ADDR_MSTAT = 5'h10;
    localparam logic [ADDR_W-1:0] ADDR_RSTAT = 5'h14;
    localparam logic [ADDR_W-1:0] ADDR_DBNC  = 5'h18;

    // Per-line configuration handed from the register file to a detector.
    typedef struct packed {
        logic edge_mode;  // 1: edge sensed, 0: level sensed
        logic act_high;   // 1: high level / rising edge, 0: low / falling
        logic dbnc;       // 1: take the filtered pin
    } line_cfg_t;

    function automatic logic is_status_addr(input logic [ADDR_W-1:0] a);
        return (a == ADDR_MSTAT) || (a == ADDR_RSTAT);
    endfunction

    function automatic int safe_clog2(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
    parameter int DB_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic din_i,
    output logic dout_o
);
    localparam int CW = gpio_irq_pkg::safe_clog2(DB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (tick_i) begin
            if (din_i != filt_q) begin
                if (cnt_q == LAST) begin
                    filt_q <= din_i;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign dout_o = filt_q;

    // R8: the filtered value moves only on a sample tick
    p_hold_off_tick_r8: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(filt_q))
        else $error("filter output changed without a tick");

    // R8: the filtered value moves only after a full run of differing samples
    p_full_run_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> ($past(cnt_q) == LAST))
        else $error("filter output changed before the run completed");
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_cfg_t cfg_i,
    input  logic      sync_i,
    input  logic      filt_i,
    input  logic      clr_i,
    output logic      raw_o
);
    logic sensed;
    logic prev_q;
    logic latch_q;
    logic hit;

    assign sensed = cfg_i.dbnc ? filt_i : sync_i;
    assign hit    = (sensed != prev_q) && (sensed == cfg_i.act_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= sensed;
            if (!cfg_i.edge_mode) begin
                latch_q <= 1'b0;
            end else begin
                latch_q <= hit | (latch_q & ~clr_i);
            end
        end
    end

    assign raw_o = cfg_i.edge_mode ? latch_q : (sensed == cfg_i.act_high);

    // R7: a pending edge appears only when the sensed pin really moved
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_q) |-> $past(sensed != prev_q))
        else $error("pending edge set without a pin transition");

    // R7: level mode holds no pending edge
    p_level_drops_r7: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.edge_mode |=> !latch_q)
        else $error("pending edge kept in level mode");

    // R4: a pending edge is sticky until cleared
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !clr_i && cfg_i.edge_mode) |=> latch_q)
        else $error("pending edge lost without a clear");

    // R5: a clear with no new event retires the edge
    p_eoi_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !hit) |=> !latch_q)
        else $error("end-of-interrupt did not clear the line");
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int  LINES    = 8,
    parameter int  DB_TICKS = 4,
    parameter int  TICK_DIV = 2,
    parameter bit  PER_LINE = 1'b0,
    localparam int IRQ_W    = PER_LINE ? LINES : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  pin_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic [IRQ_W-1:0]  irq_o
);
    localparam int TW = safe_clog2(TICK_DIV);

    logic [LINES-1:0] mode_q, pol_q, en_q, db_q;
    logic [LINES-1:0] eoi_clr;
    logic [LINES-1:0] sync_pin;
    logic [LINES-1:0] filt_pin;
    logic [LINES-1:0] raw_stat;
    logic [LINES-1:0] masked_stat;
    logic             wr_en;
    logic             tick;

    assign wr_en = bus_sel_i & bus_wr_i;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
            db_q   <= '0;
        end else if (wr_en) begin
            case (bus_addr_i)
                ADDR_MODE: mode_q <= bus_wdata_i[LINES-1:0];
                ADDR_POL:  pol_q  <= bus_wdata_i[LINES-1:0];
                ADDR_EN:   en_q   <= bus_wdata_i[LINES-1:0];
                ADDR_DBNC: db_q   <= bus_wdata_i[LINES-1:0];
                default: ;
            endcase
        end
    end

    assign eoi_clr = (wr_en && bus_addr_i == ADDR_EOI) ? bus_wdata_i[LINES-1:0] : '0;

    // sample tick for the debounce filters
    if (TICK_DIV <= 1) begin : g_tick_every
        assign tick = 1'b1;
    end else begin : g_tick_div
        logic [TW-1:0] tcnt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                tcnt_q <= '0;
            end else if (tcnt_q == TW'(TICK_DIV - 1)) begin
                tcnt_q <= '0;
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
        assign tick = (tcnt_q == TW'(TICK_DIV - 1));
    end

    gpio_irq_sync #(.W(LINES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_i),
        .sync_o  (sync_pin)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_cfg_t cfg;
        assign cfg = '{edge_mode: mode_q[i], act_high: pol_q[i], dbnc: db_q[i]};

        gpio_irq_filter #(.DB_TICKS(DB_TICKS)) u_flt (
            .clk    (clk),
            .rst    (rst),
            .tick_i (tick),
            .din_i  (sync_pin[i]),
            .dout_o (filt_pin[i])
        );

        gpio_irq_detect u_det (
            .clk    (clk),
            .rst    (rst),
            .cfg_i  (cfg),
            .sync_i (sync_pin[i]),
            .filt_i (filt_pin[i]),
            .clr_i  (eoi_clr[i]),
            .raw_o  (raw_stat[i])
        );
    end

    assign masked_stat = raw_stat & en_q;

    // combinational read port
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_MODE:  bus_rdata_o[LINES-1:0] = mode_q;
            ADDR_POL:   bus_rdata_o[LINES-1:0] = pol_q;
            ADDR_EN:    bus_rdata_o[LINES-1:0] = en_q;
            ADDR_MSTAT: bus_rdata_o[LINES-1:0] = masked_stat;
            ADDR_RSTAT: bus_rdata_o[LINES-1:0] = raw_stat;
            ADDR_DBNC:  bus_rdata_o[LINES-1:0] = db_q;
            default:    bus_rdata_o = '0;
        endcase
    end

    if (PER_LINE) begin : g_irq_each
        assign irq_o = masked_stat;
    end else begin : g_irq_shared
        assign irq_o[0] = |masked_stat;

        // R9: the shared output never fires with every line disabled
        p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
            irq_o[0] |-> (|en_q))
            else $error("shared interrupt with no line enabled");
    end

    // R10: writes aimed at status addresses leave the configuration alone
    p_status_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_status_addr(bus_addr_i)) |=>
            ($stable(mode_q) && $stable(pol_q) && $stable(en_q) && $stable(db_q)))
        else $error("status write altered a register");
endmodule

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;
    localparam int DB  = 4;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pins = 8'h00;
    logic       bsel = 1'b0;
    logic       bwr  = 1'b0;
    logic [4:0] baddr = 5'h00;
    logic [7:0] bwdata = 8'h00;
    logic [7:0] rdata_s, rdata_p;
    logic [0:0] irq_s;
    logic [7:0] irq_p;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_unit #(.DB_TICKS(DB), .TICK_DIV(DIV)) u_gpio_irq_unit (
        .clk(clk), .rst(rst), .pin_i(pins), .bus_sel_i(bsel), .bus_wr_i(bwr),
        .bus_addr_i(baddr), .bus_wdata_i(bwdata), .bus_rdata_o(rdata_s), .irq_o(irq_s));

    gpio_irq_unit #(.DB_TICKS(DB), .TICK_DIV(DIV), .PER_LINE(1'b1)) u_gpio_irq_unit_pl (
        .clk(clk), .rst(rst), .pin_i(pins), .bus_sel_i(bsel), .bus_wr_i(bwr),
        .bus_addr_i(baddr), .bus_wdata_i(bwdata), .bus_rdata_o(rdata_p), .irq_o(irq_p));

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_s1, m_s2, m_filt, m_prev, m_latch;
    logic [7:0] m_mode, m_pol, m_en, m_db;
    int         m_cnt [8];
    int         m_cyc;
    logic [7:0] t_sensed, t_clr;
    bit         t_tick;

    function automatic logic [7:0] m_sensed();
        return (m_db & m_filt) | (~m_db & m_s2);
    endfunction

    function automatic logic [7:0] m_raw();
        logic [7:0] s = m_sensed();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = m_mode[i] ? m_latch[i] : (s[i] == m_pol[i]);
        return r;
    endfunction

    function automatic logic [7:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_mode;
            5'h04: return m_pol;
            5'h0C: return m_en;
            5'h10: return m_raw() & m_en;
            5'h14: return m_raw();
            5'h18: return m_db;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_filt = 0; m_prev = 0; m_latch = 0;
            m_mode = 0; m_pol = 0; m_en = 0; m_db = 0; m_cyc = 0;
            for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        end else begin
            t_tick   = (m_cyc % DIV) == DIV - 1;
            t_sensed = m_sensed();
            t_clr    = (bsel && bwr && baddr == 5'h08) ? bwdata : 8'h00;
            for (int i = 0; i < 8; i++) begin
                if (!m_mode[i]) m_latch[i] = 1'b0;
                else m_latch[i] = ((t_sensed[i] != m_prev[i]) && (t_sensed[i] == m_pol[i]))
                                  | (m_latch[i] & ~t_clr[i]);
                if (t_tick) begin
                    if (m_s2[i] != m_filt[i]) begin
                        if (m_cnt[i] == DB - 1) begin
                            m_filt[i] = m_s2[i];
                            m_cnt[i] = 0;
                        end else begin
                            m_cnt[i] = m_cnt[i] + 1;
                        end
                    end else begin
                        m_cnt[i] = 0;
                    end
                end
            end
            m_prev = t_sensed;
            m_s2 = m_s1;
            m_s1 = pins;
            if (bsel && bwr) begin
                case (baddr)
                    5'h00: m_mode = bwdata;
                    5'h04: m_pol  = bwdata;
                    5'h0C: m_en   = bwdata;
                    5'h18: m_db   = bwdata;
                    default: ;
                endcase
            end
            m_cyc++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R9 shared output vs model", 32'(irq_s[0]), 32'(|(m_raw() & m_en)));
            check("R9 per-line outputs vs model", 32'(irq_p), 32'(m_raw() & m_en));
            check("R2 read data vs model", 32'(rdata_s), 32'(m_read(baddr)));
            check("R2 per-line variant read vs model", 32'(rdata_p), 32'(m_read(baddr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bsel = 1; bwr = 1; baddr = a; bwdata = d;
        @(negedge clk); #1;
        bwr = 0; bsel = 0; bwdata = 0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        bsel = 1; bwr = 0; baddr = a;
        #1;
        check(tag, 32'(rdata_s), 32'(exp));
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk); #1;
        pins = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;

        // R1: reset state
        rd_chk(5'h00, 8'h00, "R1 mode after reset");
        rd_chk(5'h04, 8'h00, "R1 polarity after reset");
        rd_chk(5'h0C, 8'h00, "R1 enable after reset");
        rd_chk(5'h18, 8'h00, "R1 debounce after reset");
        rd_chk(5'h14, 8'hFF, "R1 raw status level-low with low pins");
        rd_chk(5'h10, 8'h00, "R1 gated status after reset");
        check("R1 irq low after reset", 32'(irq_s), 32'h0);

        // R2: register map
        wr(5'h00, 8'hA5); rd_chk(5'h00, 8'hA5, "R2 mode readback");
        wr(5'h04, 8'h3C); rd_chk(5'h04, 8'h3C, "R2 polarity readback");
        wr(5'h18, 8'h0F); rd_chk(5'h18, 8'h0F, "R2 debounce readback");
        wr(5'h0C, 8'h5A); rd_chk(5'h0C, 8'h5A, "R2 enable readback");
        rd_chk(5'h08, 8'h00, "R2 end-of-interrupt reads zero");
        rd_chk(5'h1C, 8'h00, "R2 unmapped address reads zero");
        wr(5'h00, 8'h00); wr(5'h04, 8'h00); wr(5'h18, 8'h00); wr(5'h0C, 8'h00);

        // R11: two-edge latency, level-low lines
        @(negedge clk); #1;
        bsel = 1; bwr = 0; baddr = 5'h14; pins = 8'hFF;
        @(negedge clk); #1;
        check("R11 raw unchanged after one edge", 32'(rdata_s), 32'hFF);
        @(negedge clk); #1;
        check("R11 raw updated after two edges", 32'(rdata_s), 32'h00);

        // R3: level sensing with polarity, end-of-interrupt no effect
        wr(5'h04, 8'hFF);
        rd_chk(5'h14, 8'hFF, "R3 level-high lines with high pins");
        set_pins(8'hFB); idle(3);
        rd_chk(5'h14, 8'hFB, "R3 line 2 low drops its level");
        wr(5'h08, 8'hFF);
        rd_chk(5'h14, 8'hFB, "R3 end-of-interrupt ignored on level lines");

        // R4: edge sensing
        set_pins(8'h00); idle(3);
        rd_chk(5'h14, 8'h00, "R3 level-high lines with low pins");
        wr(5'h04, 8'h0F);
        wr(5'h00, 8'hFF);
        rd_chk(5'h14, 8'h00, "R7 switching to edge mode creates no event");
        set_pins(8'h01); idle(3);
        rd_chk(5'h14, 8'h01, "R4 rising edge latched on line 0");
        set_pins(8'h11); idle(3);
        rd_chk(5'h14, 8'h01, "R4 rising edge ignored on falling line 4");
        set_pins(8'h01); idle(3);
        rd_chk(5'h14, 8'h11, "R4 falling edge latched on line 4");
        set_pins(8'h00); idle(3);
        rd_chk(5'h14, 8'h11, "R4 pending edges stay after pins return");

        // R5: end-of-interrupt
        wr(5'h08, 8'h01);
        rd_chk(5'h14, 8'h10, "R5 write-one clears line 0 only");
        wr(5'h08, 8'h00);
        rd_chk(5'h14, 8'h10, "R5 zero bits leave lines untouched");
        set_pins(8'h02);
        @(negedge clk); #1;
        @(negedge clk); #1;
        bsel = 1; bwr = 1; baddr = 5'h08; bwdata = 8'h02;
        @(negedge clk); #1;
        bwr = 0; bsel = 0; bwdata = 0;
        rd_chk(5'h14, 8'h12, "R5 new edge wins over simultaneous clear");
        wr(5'h08, 8'hFF);
        rd_chk(5'h14, 8'h00, "R5 clear all");

        // R6 / R9: gating and outputs
        set_pins(8'h03); idle(3);
        rd_chk(5'h14, 8'h01, "R4 line 0 rises again");
        wr(5'h0C, 8'h10);
        rd_chk(5'h10, 8'h00, "R6 disabled line hidden in gated status");
        check("R9 shared output low while gated off", 32'(irq_s), 32'h0);
        wr(5'h0C, 8'h11);
        rd_chk(5'h10, 8'h01, "R6 enabled line shown in gated status");
        check("R9 shared output high", 32'(irq_s), 32'h1);
        check("R9 per-line output 0 high", 32'(irq_p), 32'h01);
        wr(5'h08, 8'h01);
        rd_chk(5'h10, 8'h00, "R6 gated status clears with the edge");
        check("R9 shared output drops after clear", 32'(irq_s), 32'h0);

        // R7: reconfiguration never manufactures events
        wr(5'h0C, 8'h00);
        wr(5'h04, 8'hF0);
        wr(5'h04, 8'h0F);
        rd_chk(5'h14, 8'h00, "R7 polarity writes create no event");
        wr(5'h00, 8'h00);
        rd_chk(5'h14, 8'hF3, "R3 level view of pins 03 against polarity 0F");
        wr(5'h00, 8'hFF);
        rd_chk(5'h14, 8'h00, "R7 level-to-edge switch creates no event");
        set_pins(8'h07); idle(3);
        rd_chk(5'h14, 8'h04, "R4 line 2 rising edge");
        wr(5'h00, 8'h00);
        wr(5'h00, 8'hFF);
        rd_chk(5'h14, 8'h00, "R7 level mode discarded the pending edge");

        // R8: debounce on line 7 (rising)
        set_pins(8'h00); idle(3);
        wr(5'h08, 8'hFF);
        wr(5'h04, 8'h8F);
        wr(5'h18, 8'h80);
        idle(20);
        set_pins(8'h80);
        set_pins(8'h00);
        idle(20);
        rd_chk(5'h14, 8'h00, "R8 one-cycle glitch rejected");
        set_pins(8'h80); idle(5);
        rd_chk(5'h14, 8'h00, "R8 change not yet accepted");
        idle(16);
        rd_chk(5'h14, 8'h80, "R8 held change accepted and latched");

        // R10: status writes ignored
        wr(5'h10, 8'hFF);
        wr(5'h14, 8'h00);
        rd_chk(5'h14, 8'h80, "R10 raw status unaffected by writes");
        rd_chk(5'h0C, 8'h00, "R10 enable unaffected");
        rd_chk(5'h00, 8'hFF, "R10 mode unaffected");
        rd_chk(5'h04, 8'h8F, "R10 polarity unaffected");
        rd_chk(5'h18, 8'h80, "R10 debounce unaffected");

        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule